// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This combinational unit sits beside the execute stage of a 32-bit pipeline. It takes the current instruction word, that instruction's program counter and the two source operand values. From these it decides whether control leaves the sequential path. It returns the address to fetch after the delay slot, whether the delay-slot instruction must be discarded, and whether the return address goes to the link register.

The unit handles the following groups:
- Unconditional jumps and jump-and-link.
- Compare-two-register branches.
- Sign/zero tests on one register.
- The register-immediate sub-group, selected by the rt field.
- "Likely" variants, which cancel the delay slot when they fall through.

Register-immediate link forms always write the return address, whether or not they are taken. An rt code the sub-group does not define raises a trap flag. In that case the unit does not redirect, link or annul. Fetch and the delay slot's execution belong to the surrounding pipeline.

Top module: `branch_resolve`

## Requirements
- R1: A taken conditional branch sets next_pc to pc + 4 + (sign-extended instr[15:0] shifted left by 2).
- R2: Opcode 2 (jump) and opcode 3 (jump-and-link) are always taken. Their next_pc is {pc[31:28], instr[25:0], 2'b00}.
- R3: Opcode 3, and opcode 1 with instr[20:16] in {16,17,18,19}, assert link_we with link_value = pc + 8. For the opcode 1 forms this holds whether the branch is taken or not. No other instruction asserts link_we.
- R4: Opcodes 4/20 are taken when rs_val equals rt_val. Opcodes 5/21 are taken when they differ.
- R5: Opcodes 6/22 are taken when rs_val[31] is 1 or rs_val is zero. Opcodes 7/23 are taken when rs_val[31] is 0 and rs_val is non-zero.
- R6: For opcode 1, instr[20:16] bit 0 clear means taken when rs_val[31] is 1. Bit 0 set means taken when rs_val[31] is 0. Codes 2, 3, 18 and 19 are the likely forms.
- R7: A likely branch that is not taken asserts annul and sets next_pc to pc + 8. Likely branches are opcodes 20–23 and the likely opcode-1 codes. annul is never asserted together with taken.
- R8: A non-likely branch that is not taken leaves annul low and sets next_pc to pc + 4.
- R9: Opcode 1 with an rt code outside {0–3, 16–19} asserts trap and holds taken, annul and link_we low. next_pc is then pc + 4.
- R10: Every opcode outside {1–7, 20–23} has no effect: taken, annul, link_we and trap are 0 and next_pc is pc + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being resolved |
| pc | input | 32 | Address of that instruction |
| rs_val | input | 32 | Value of the rs source register |
| rt_val | input | 32 | Value of the rt source register |
| taken | output | 1 | Control transfers to the target |
| annul | output | 1 | Discard the delay-slot instruction |
| link_we | output | 1 | Write link_value to register 31 |
| link_value | output | 32 | Return address, pc + 8 |
| next_pc | output | 32 | Address to fetch after the delay slot |
| trap | output | 1 | Undefined register-immediate code |

## Verification
The bench sweeps all 64 opcodes and, for opcode 1, all 32 rt codes. Operands include zero, one, the largest positive value, the most negative value and all ones. A design that tested only the sign bit for the "less or equal zero" forms would miss the zero case and fall through on rs = 0. A design that gated the link write on the branch being taken would lose the return address on a not-taken link form. Negative offsets and a pc near the top of the address space expose a target adder that zero-extends the offset or lets the jump index overwrite pc[31:28]. The undefined rt codes must raise trap without also redirecting or linking.

// File: rtl/branch_resolve.sv
module branch_resolve (
  input  logic [31:0] instr,
  input  logic [31:0] pc,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic        taken,
  output logic        annul,
  output logic        link_we,
  output logic [31:0] link_value,
  output logic [31:0] next_pc,
  output logic        trap
);
  localparam int W = 32;
  localparam int OFFW = 16;
  localparam int IDXW = 26;

  logic [5:0] op;
  logic [4:0] rcode;
  logic [W-1:0] seq4, seq8, br_tgt, j_tgt;
  logic rs_neg, rs_zero, ops_eq;
  logic is_cti, cond, likely, link, jump, bad;

  assign op      = instr[31:26];
  assign rcode   = instr[20:16];
  assign seq4    = pc + W'(4);
  assign seq8    = pc + W'(8);
  assign br_tgt  = seq4 + {{(W-OFFW-2){instr[OFFW-1]}}, instr[OFFW-1:0], 2'b00};
  assign j_tgt   = {pc[W-1:IDXW+2], instr[IDXW-1:0], 2'b00};
  assign rs_neg  = rs_val[W-1];
  assign rs_zero = (rs_val == '0);
  assign ops_eq  = (rs_val == rt_val);

  always_comb begin
    is_cti = 1'b0;
    cond   = 1'b0;
    likely = 1'b0;
    link   = 1'b0;
    jump   = 1'b0;
    bad    = 1'b0;
    case (op)
      6'd1: begin
        if (rcode[3:2] != 2'b00) begin
          bad = 1'b1;
        end else begin
          is_cti = 1'b1;
          likely = rcode[1];
          link   = rcode[4];
          cond   = rcode[0] ? !rs_neg : rs_neg;
        end
      end
      6'd2, 6'd3: begin
        is_cti = 1'b1;
        jump   = 1'b1;
        cond   = 1'b1;
        link   = op[0];
      end
      6'd4, 6'd20: begin is_cti = 1'b1; likely = op[4]; cond = ops_eq; end
      6'd5, 6'd21: begin is_cti = 1'b1; likely = op[4]; cond = !ops_eq; end
      6'd6, 6'd22: begin is_cti = 1'b1; likely = op[4]; cond = rs_neg || rs_zero; end
      6'd7, 6'd23: begin is_cti = 1'b1; likely = op[4]; cond = !rs_neg && !rs_zero; end
      default: ;
    endcase
  end

  assign taken      = is_cti & cond;
  assign annul      = is_cti & likely & ~cond;
  assign link_we    = link;
  assign link_value = seq8;
  assign trap       = bad;
  assign next_pc    = taken ? (jump ? j_tgt : br_tgt) : (annul ? seq8 : seq4);

  always_comb begin
    p_annul_excl_r7: assert (!(annul && taken)) else $error("annul with taken");
    p_annul_pc_r7: assert (!annul || next_pc == pc + 32'd8) else $error("annul next_pc");
    p_fallthrough_r8: assert (taken || annul || next_pc == pc + 32'd4) else $error("fall-through next_pc");
    p_trap_quiet_r9: assert (!trap || (!taken && !annul && !link_we)) else $error("trap not quiet");
    p_link_addr_r3: assert (!link_we || link_value == pc + 32'd8) else $error("link value");
    p_jump_region_r2: assert (!(taken && (op == 6'd2 || op == 6'd3)) || next_pc[31:28] == pc[31:28])
      else $error("jump region");
  end
endmodule

// File: tb/branch_resolve_tb_top.sv
module branch_resolve_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [31:0] instr, pc, rs_val, rt_val, link_value, next_pc;
  logic taken, annul, link_we, trap;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  branch_resolve dut_i (
    .instr(instr), .pc(pc), .rs_val(rs_val), .rt_val(rt_val),
    .taken(taken), .annul(annul), .link_we(link_we),
    .link_value(link_value), .next_pc(next_pc), .trap(trap)
  );

  function automatic string tag_of(int o, int rc);
    if (o == 1) begin
      if (!((rc >= 0 && rc <= 3) || (rc >= 16 && rc <= 19))) return "R9";
      if (rc >= 16) return "R3";
      return "R6";
    end
    if (o == 2) return "R2";
    if (o == 3) return "R3";
    if (o == 4 || o == 5 || o == 20 || o == 21) return "R4";
    if (o == 6 || o == 7 || o == 22 || o == 23) return "R5";
    return "R10";
  endfunction

  task automatic check_one(input int o, input int rc, input logic [31:0] p,
                           input logic [31:0] a, input logic [31:0] b,
                           input logic [15:0] imm);
    logic [31:0] w;
    bit e_t, e_an, e_lk, e_tr, lik, cti;
    logic [31:0] e_np, brt;
    w = {o[5:0], 5'd9, rc[4:0], imm};
    instr = w; pc = p; rs_val = a; rt_val = b;
    #2;
    e_t = 0; e_lk = 0; e_tr = 0; lik = 0; cti = 0;
    brt = p + 32'd4 + 32'($signed(imm) * 4);
    e_np = p + 32'd4;
    case (o)
      1: begin
        if ((rc >= 0 && rc <= 3) || (rc >= 16 && rc <= 19)) begin
          cti = 1;
          lik = (rc % 4) >= 2;
          e_lk = rc >= 16;
          e_t = (rc % 2 == 1) ? ($signed(a) >= 0) : ($signed(a) < 0);
        end else e_tr = 1;
      end
      2, 3: begin cti = 1; e_t = 1; e_lk = (o == 3); end
      4, 20: begin cti = 1; e_t = (a == b); end
      5, 21: begin cti = 1; e_t = (a != b); end
      6, 22: begin cti = 1; e_t = ($signed(a) <= 0); end
      7, 23: begin cti = 1; e_t = ($signed(a) > 0); end
      default: ;
    endcase
    if (o >= 20 && o <= 23) lik = 1;
    e_an = cti && lik && !e_t;
    if (e_t) e_np = (o == 2 || o == 3) ? ((p & 32'hF000_0000) | ((w & 32'h03FF_FFFF) << 2)) : brt;
    else if (e_an) e_np = p + 32'd8;
    total++;
    if (taken !== e_t || annul !== e_an || link_we !== e_lk || trap !== e_tr ||
        next_pc !== e_np || (e_lk && link_value !== p + 32'd8)) begin
      bad++;
      $display("FAIL %s (R1 R7 R8 target/annul) op=%0d rc=%0d rs=%h rt=%h: got t=%0b a=%0b l=%0b tr=%0b np=%h lv=%h exp t=%0b a=%0b l=%0b tr=%0b np=%h lv=%h",
               tag_of(o, rc), o, rc, a, b, taken, annul, link_we, trap, next_pc, link_value,
               e_t, e_an, e_lk, e_tr, e_np, p + 32'd8);
    end
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] pcs [3];
    logic [31:0] vals [5];
    logic [15:0] imms [2];
    pcs = '{32'h0000_1000, 32'h7FFF_FFFC, 32'hF000_0010};
    vals = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};
    imms = '{16'h0004, 16'hFFFE};
    instr = '0; pc = 32'h100; rs_val = '0; rt_val = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    total++;
    if (taken !== 0 || annul !== 0 || link_we !== 0 || trap !== 0 || next_pc !== 32'h104) begin
      bad++;
      $display("FAIL R10 idle word: got np=%h t=%0b exp np=00000104 t=0", next_pc, taken);
    end
    @(negedge clk);
    foreach (pcs[pi])
      for (int o = 0; o < 64; o++)
        for (int rc = 0; rc < ((o == 1) ? 32 : 1); rc++)
          foreach (vals[ai])
            foreach (vals[bi])
              foreach (imms[ii])
                check_one(o, (o == 1) ? rc : 5, pcs[pi], vals[ai], vals[bi], imms[ii]);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule